// File: doc/BRIEF.md
# Configurable Host Bus Slave Port

This block is a synchronous slave port. Embedded processors of four bus families reach a small bank of 32-bit registers through it, with no glue logic in between. Two family straps and one ready-hold strap are latched once after reset. From then on the latched family sets four things:

- the polarity of the wait/ready line,
- the polarity of the interrupt line,
- the polarity of the DMA transfer strobe,
- whether the top address bit gives the transfer direction.

A cycle begins on a clock edge that sees both the bus-start and chip-select strobes low. An internal counter holds off ready for a set number of edges. Ready is then shown for one cycle, and in that same cycle read data appears on the data bus. A write is committed on the edge that ends the ready cycle, and only the byte lanes whose write strobes were low at the start of the cycle are changed. The tristate lines are modelled as value/enable pairs, so the pads stay outside the block.

Top module: `hb_slave`

## Requirements
- R1: The family (`mode_strap`: 0 = family A, 1 = family B, 2 = family C, 3 = family D) and `hold_strap` are latched on the first clock edge after the internal reset release. Later strap changes have no effect until the next reset.
- R2: `rdy_oe` is high exactly in the cycles that follow a clock edge on which `cs_n` was sampled low. It is low during and after reset.
- R3: Ready is active high in family A and active low in families B, C and D. The inactive level is the complement of the active level.
- R4: With `WAIT_CYC` = 2, ready first shows its active level after the third clock edge counted from the edge that sampled `bs_n` and `cs_n` both low.
- R5: In the cycle after the ready cycle, while the chip stays selected, `rdy_o` returns to the inactive level when `hold_strap` was 0. It stays at the active level when `hold_strap` was 1.
- R6: `irq_o` reflects `irq_req` active low in families A and B, and active high in families C and D.
- R7: `dreq_o` reflects `dma_req` active low in every family. `dack_o` follows the active-high `dack_i`.
- R8: `dtack_o` is high when `dtack_i` is at its active level. That level is high in families A and B and low in families C and D.
- R9: A write updates byte lane i (bits 8i+7..8i) only when `we_n[i]` was low at the start of the cycle.
- R10: On a read, `data_oe` rises in the ready cycle with the addressed data on `data_o`. It falls after the first edge that samples `cs_n` high, or, outside family C, `rd_n` high.
- R11: In family C, `addr[22]` = 1 marks a write and `addr[22]` = 0 marks a read. `rd_n` is ignored, and only `addr[21:0]` is decoded.
- R12: Eight registers sit at double-word addresses 0 to 7, with all higher decoded bits zero. A write to any other address changes nothing, and a read from it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_strap | input | 2 | Bus family strap |
| hold_strap | input | 1 | Post-cycle ready level strap |
| bs_n | input | 1 | Bus-start strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| we_n | input | 4 | Per-byte write strobes, active low |
| addr | input | 23 | Double-word address |
| data_i | input | 32 | Write data from the bus |
| data_o | output | 32 | Read data to the bus |
| data_oe | output | 1 | Data bus drive enable |
| rdy_o | output | 1 | Wait/ready level |
| rdy_oe | output | 1 | Wait/ready drive enable |
| irq_req | input | 1 | Internal interrupt request, active high |
| irq_o | output | 1 | Interrupt line at the family's polarity |
| dma_req | input | 1 | Internal DMA request, active high |
| dreq_o | output | 1 | DMA request line, active low |
| dack_i | input | 1 | DMA acknowledge from the bus |
| dtack_i | input | 1 | DMA transfer strobe from the bus |
| dack_o | output | 1 | Acknowledge, normalised active high |
| dtack_o | output | 1 | Transfer strobe, normalised active high |

## Verification
Most faults show up within one or two cycles of the bus-start strobe:

- A wrong latched family inverts ready, interrupt or transfer strobe at once. A stale latch shows as soon as the straps move after reset.
- A fault in the wait counter or the sequencer moves the first ready cycle, or leaves data on the bus after the release edge. The bench measures this edge by edge.
- A wrong lane, decode or direction fault stays hidden until the location is read back. The bench therefore follows every write with a full read sweep of all registers and of unmapped addresses.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    FAM_A = 2'd0,
    FAM_B = 2'd1,
    FAM_C = 2'd2,
    FAM_D = 2'd3
  } fam_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_ACK  = 2'd2,
    S_DONE = 2'd3
  } seq_e;

  typedef struct packed {
    logic rdy_act;     // level meaning "transfer complete"
    logic irq_act;     // asserted interrupt level
    logic dtack_act;   // asserted transfer strobe level
    logic dir_on_addr; // top address bit carries direction
  } pol_t;

  function automatic pol_t pol_of(fam_e f);
    pol_t p;
    p.rdy_act     = (f == FAM_A);
    p.irq_act     = (f == FAM_C) || (f == FAM_D);
    p.dtack_act   = (f == FAM_A) || (f == FAM_B);
    p.dir_on_addr = (f == FAM_C);
    return p;
  endfunction

endpackage

// File: rtl/hb_strap.sv
module hb_strap
  import hb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_strap,
  input  logic       hold_strap,
  output fam_e       fam,
  output logic       hold,
  output logic       cap
);
  logic cap_q, hold_q;
  fam_e fam_q;
  logic cap_en;

  assign cap_en = !cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      fam_q  <= FAM_A;
      hold_q <= 1'b0;
    end else if (cap_en) begin
      cap_q  <= 1'b1;
      fam_q  <= fam_e'(mode_strap);
      hold_q <= hold_strap;
    end
  end

  assign fam  = fam_q;
  assign hold = hold_q;
  assign cap  = cap_q;
endmodule

// File: rtl/hb_seq.sv
module hb_seq
  import hb_pkg::*;
#(
  parameter int WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bs_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic dir_on_addr,
  input  logic addr_dir,
  output logic start,
  output logic ack,
  output logic done,
  output logic rd_q,
  output logic sel_q
);
  localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYC - 1);

  seq_e state_q, state_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic rd_nx, go, rel;

  assign go  = !bs_n && !cs_n;
  assign rel = cs_n || (rd_q && !dir_on_addr && rd_n);

  always_comb begin
    state_nx = state_q;
    cnt_nx   = cnt_q;
    start    = 1'b0;
    case (state_q)
      S_IDLE: if (go) begin
        state_nx = S_WAIT;
        cnt_nx   = CNT_LOAD;
        start    = 1'b1;
      end
      S_WAIT: begin
        if (cs_n)              state_nx = S_IDLE;
        else if (cnt_q == '0)  state_nx = S_ACK;
        else                   cnt_nx   = cnt_q - 1'b1;
      end
      S_ACK:  state_nx = cs_n ? S_IDLE : S_DONE;
      S_DONE: begin
        if (rel) state_nx = S_IDLE;
        else if (go) begin
          state_nx = S_WAIT;
          cnt_nx   = CNT_LOAD;
          start    = 1'b1;
        end
      end
      default: state_nx = S_IDLE;
    endcase
  end

  assign rd_nx = dir_on_addr ? !addr_dir : !rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      cnt_q   <= cnt_nx;
      sel_q   <= !cs_n;
      if (start) rd_q <= rd_nx;
    end
  end

  assign ack  = (state_q == S_ACK);
  assign done = (state_q == S_DONE);
endmodule

// File: rtl/hb_regs.sv
module hb_regs #(
  parameter int DW    = 32,
  parameter int NREGS = 8,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DW/8-1:0]   lanes,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  localparam int LANES = DW / 8;

  logic [7:0] mem_q [NREGS][LANES];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic lane_en;
      assign lane_en = wr_en && (idx == IDX_W'(r)) && lanes[b];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mem_q[r][b] <= '0;
        else if (lane_en) mem_q[r][b] <= wdata[b*8 +: 8];
      end
    end
  end

  always_comb begin
    for (int b = 0; b < LANES; b++) rdata[b*8 +: 8] = mem_q[idx][b];
  end
endmodule

// File: rtl/hb_slave.sv
module hb_slave
  import hb_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 23,
  parameter int NREGS    = 8,
  parameter int WAIT_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_strap,
  input  logic          hold_strap,
  input  logic          bs_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic [DW/8-1:0] we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic          rdy_o,
  output logic          rdy_oe,
  input  logic          irq_req,
  output logic          irq_o,
  input  logic          dma_req,
  output logic          dreq_o,
  input  logic          dack_i,
  input  logic          dtack_i,
  output logic          dack_o,
  output logic          dtack_o
);
  localparam int LANES = DW / 8;
  localparam int IDX_W = (NREGS < 2) ? 1 : $clog2(NREGS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  fam_e fam_w;
  logic hold_w, cap_w;
  pol_t pol_w;
  logic rdy_act_w;

  hb_strap u_strap (
    .clk(clk), .rst_n(srst_n), .mode_strap(mode_strap), .hold_strap(hold_strap),
    .fam(fam_w), .hold(hold_w), .cap(cap_w)
  );

  assign pol_w     = pol_of(fam_w);
  assign rdy_act_w = pol_w.rdy_act;

  logic start, ack, done, rd_q, sel_q;

  hb_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
    .clk(clk), .rst_n(srst_n), .bs_n(bs_n), .cs_n(cs_n), .rd_n(rd_n),
    .dir_on_addr(pol_w.dir_on_addr), .addr_dir(addr[AW-1]),
    .start(start), .ack(ack), .done(done), .rd_q(rd_q), .sel_q(sel_q)
  );

  // address and lane capture at cycle start
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] lanes_q;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q  <= '0;
      lanes_q <= '0;
    end else if (start) begin
      addr_q  <= addr;
      lanes_q <= ~we_n;
    end
  end

  logic [AW-1:0] eff_addr;
  logic          mapped;
  always_comb begin
    eff_addr = addr_q;
    if (pol_w.dir_on_addr) eff_addr[AW-1] = 1'b0;
    mapped = ((eff_addr >> IDX_W) == '0);
  end

  logic          wr_en;
  logic [DW-1:0] rdata;
  assign wr_en = ack && !rd_q && mapped;

  hb_regs #(.DW(DW), .NREGS(NREGS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .idx(addr_q[IDX_W-1:0]),
    .lanes(lanes_q), .wdata(data_i), .rdata(rdata)
  );

  assign data_oe = rd_q && (ack || done);
  assign data_o  = (data_oe && mapped) ? rdata : '0;

  assign rdy_oe = sel_q;
  assign rdy_o  = (ack || (done && hold_w)) ? pol_w.rdy_act : ~pol_w.rdy_act;

  assign irq_o   = irq_req ? pol_w.irq_act : ~pol_w.irq_act;
  assign dreq_o  = ~dma_req;
  assign dack_o  = dack_i;
  assign dtack_o = (dtack_i == pol_w.dtack_act);
endmodule

// File: rtl/hb_slave_chk.sv
module hb_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rdy_o,
  input logic       rdy_oe,
  input logic       data_oe,
  input logic [1:0] fam,
  input logic       cap,
  input logic       rdy_act
);
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && $past(cap)) |-> $stable(fam)); // R1

  AST_RDY_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_oe |-> $past(!cs_n)); // R2

  AST_NO_READY_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_oe && !$past(rdy_oe)) |-> (rdy_o != rdy_act)); // R4

  AST_DATA_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> (rdy_o == rdy_act)); // R10

  AST_DATA_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> rdy_oe); // R10
endmodule

bind hb_slave hb_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rdy_o(rdy_o), .rdy_oe(rdy_oe),
  .data_oe(data_oe), .fam(fam_w), .cap(cap_w), .rdy_act(rdy_act_w)
);

// File: tb/hb_slave_bench.sv
module hb_slave_bench;
  localparam int WAIT_CYC = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_strap;
  logic        hold_strap;
  logic        bs_n, cs_n, rd_n;
  logic [3:0]  we_n;
  logic [22:0] addr;
  logic [31:0] data_i, data_o;
  logic        data_oe, rdy_o, rdy_oe;
  logic        irq_req, irq_o, dma_req, dreq_o, dack_i, dtack_i, dack_o, dtack_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int  fam;
  bit  hold;
  logic [31:0] model [8];

  always #2 clk = ~clk;

  hb_slave u_hb_slave (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .hold_strap(hold_strap),
    .bs_n(bs_n), .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n), .addr(addr),
    .data_i(data_i), .data_o(data_o), .data_oe(data_oe), .rdy_o(rdy_o),
    .rdy_oe(rdy_oe), .irq_req(irq_req), .irq_o(irq_o), .dma_req(dma_req),
    .dreq_o(dreq_o), .dack_i(dack_i), .dtack_i(dtack_i), .dack_o(dack_o),
    .dtack_o(dtack_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic rdy_act_m();
    return (fam == 0);
  endfunction

  task automatic bus_cycle(input bit wr, input logic [22:0] a, input logic [3:0] lanes,
                           input logic [31:0] wd, output logic [31:0] rd);
    int lat;
    logic ra;
    ra = rdy_act_m();
    @(negedge clk);
    cs_n = 1'b0; bs_n = 1'b0; addr = a; data_i = wd;
    if (fam == 2) begin
      addr[22] = wr;
      rd_n = 1'b1;
    end else begin
      rd_n = wr;
    end
    we_n = wr ? ~lanes : 4'hF;
    lat = 0;
    do begin
      @(negedge clk);
      bs_n = 1'b1;
      lat++;
    end while (!(rdy_oe && rdy_o == ra) && lat < 20);
    chk(lat == WAIT_CYC + 1, "R4 ready latency", lat, WAIT_CYC + 1);
    rd = data_o;
    if (!wr) chk(data_oe == 1'b1, "R10 data on in ready cycle", data_oe, 1);
    @(negedge clk);
    chk(rdy_oe == 1'b1, "R2 driven while selected", rdy_oe, 1);
    chk(rdy_o == (hold ? ra : ~ra), "R5 R3 post-cycle level", rdy_o, hold ? ra : ~ra);
    if (!wr) chk(data_oe == 1'b1, "R10 data held", data_oe, 1);
    if (!wr && fam != 2) begin
      rd_n = 1'b1;
      @(negedge clk);
      chk(data_oe == 1'b0, "R10 release on read strobe", data_oe, 0);
      chk(rdy_oe == 1'b1, "R2 still selected", rdy_oe, 1);
      chk(rdy_o == ~ra, "R3 not-ready after release", rdy_o, ~ra);
    end
    cs_n = 1'b1; rd_n = 1'b1; we_n = 4'hF;
    @(negedge clk);
    chk(rdy_oe == 1'b0, "R2 high impedance when deselected", rdy_oe, 0);
    chk(data_oe == 1'b0, "R10 release on chip select", data_oe, 0);
  endtask

  task automatic do_reset(input int f, input bit h);
    fam = f; hold = h;
    rst_n = 1'b0;
    mode_strap = 2'(f); hold_strap = h;
    bs_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1; we_n = 4'hF; addr = '0; data_i = '0;
    irq_req = 0; dma_req = 0; dack_i = 0; dtack_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdy_oe == 1'b0, "R2 reset state", rdy_oe, 0);
    chk(data_oe == 1'b0, "R10 reset state", data_oe, 0);
    for (int i = 0; i < 8; i++) model[i] = '0;
    // straps move after capture: must not matter
    mode_strap = ~mode_strap;
    hold_strap = ~hold_strap;
  endtask

  initial begin : main
    logic [31:0] rv;
    for (int cfg = 0; cfg < 8; cfg++) begin
      do_reset(cfg >> 1, cfg[0]);
      for (int v = 0; v < 16; v++) begin
        logic ia, da;
        ia = (fam >= 2);
        da = (fam < 2);
        @(negedge clk);
        irq_req = v[0]; dma_req = v[1]; dack_i = v[2]; dtack_i = v[3];
        #1;
        chk(irq_o == (v[0] ? ia : ~ia), "R6 R1 interrupt polarity", irq_o, v[0] ? ia : ~ia);
        chk(dreq_o == !v[1], "R7 dma request polarity", dreq_o, !v[1]);
        chk(dack_o == v[2], "R7 acknowledge", dack_o, v[2]);
        chk(dtack_o == (v[3] == da), "R8 transfer strobe polarity", dtack_o, v[3] == da);
      end
      irq_req = 0; dma_req = 0; dack_i = 0; dtack_i = 0;
      for (int i = 0; i < 8; i++) begin
        bus_cycle(1'b0, 23'(i), 4'h0, '0, rv);
        chk(rv == 32'h0, "R12 registers clear after reset", rv, 0);
      end
      for (int i = 0; i < 8; i++) begin
        logic [3:0]  ln;
        logic [31:0] wd;
        ln = 4'((i + cfg) % 15 + 1);
        wd = (32'h9E3779B9 * 32'(i + 1)) ^ {8{4'(cfg)}};
        bus_cycle(1'b1, 23'(i), ln, wd, rv);
        for (int b = 0; b < 4; b++) if (ln[b]) model[i][b*8 +: 8] = wd[b*8 +: 8];
      end
      // unmapped writes
      bus_cycle(1'b1, 23'd8, 4'hF, 32'hDEADBEEF, rv);
      bus_cycle(1'b1, 23'h200000, 4'hF, 32'hCAFEF00D, rv);
      for (int i = 0; i < 8; i++) begin
        bus_cycle(1'b0, 23'(i), 4'h0, '0, rv);
        chk(rv == model[i], fam == 2 ? "R11 R9 read back" : "R9 R12 read back", rv, model[i]);
      end
      bus_cycle(1'b0, 23'd8, 4'h0, '0, rv);
      chk(rv == 32'h0, "R12 unmapped read", rv, 0);
      bus_cycle(1'b0, 23'h200000, 4'h0, '0, rv);
      chk(rv == 32'h0, "R12 unmapped high read", rv, 0);
      if (fam != 2) begin
        bus_cycle(1'b0, 23'h400001, 4'h0, '0, rv);
        chk(rv == 32'h0, "R12 top bit decoded outside family C", rv, 0);
      end
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule